// File: doc/BRIEF.md
# Serial-In Shift-and-Store Register

This block turns a serial bit stream into a parallel word. A chain of shift stages advances on every rising edge of the shift clock: the serial input enters the first stage and each later stage takes the value of the stage before it. A bank of level-sensitive store latches sits behind the chain. While the strobe is high, the latches pass the chain contents straight through to the parallel output. When the strobe falls, the latches freeze the word they hold. A parallel output enable either drives the stored word or releases the parallel bus.

The last stage leaves the block on two cascade outputs. The fast output changes on the rising clock edge, together with the last stage. The slow output copies the fast one on the falling edge that follows, which gives a downstream device half a clock more hold time. Either output can feed the serial input of a further device to build a longer chain. The parallel result comes out in two forms. One is a three-state bus. The other is a plain data vector with a single drive flag, for flows that do not allow internal three-state nets. An active-low asynchronous reset clears every storage element; it exists for simulation start-up.

Top module: `shift_store_reg`

## Requirements
- R1: On each rising `sclk` edge, `sdin` enters stage 1 and each stage n (n > 1) takes the value that stage n-1 held before the edge.
- R2: After each rising `sclk` edge, `ser_fast` equals the new content of the last stage.
- R3: On each falling `sclk` edge, `ser_slow` takes the value of `ser_fast`. Between a rising edge and the next falling edge, `ser_slow` keeps its earlier value.
- R4: While `strobe` is high, `par_data` follows the shift stages. Bit i of `par_data` shows stage i+1, so bit 0 is the stage fed by `sdin` and bit STAGES-1 is the last stage.
- R5: A falling `strobe` freezes `par_data`. While `strobe` stays low, `par_data` does not change, even when `sclk` keeps running.
- R6: With `oe` low, `par_drive` is 0 and `par_bus` is released (high impedance). With `oe` high, `par_drive` is 1 and `par_bus` equals `par_data`. `oe` never changes `par_data`.
- R7: The chain, `ser_fast` and `ser_slow` keep shifting whatever the levels of `strobe` and `oe`.
- R8: While `rst_n` is low, the stages, the latches, `ser_fast` and `ser_slow` are all 0, whatever the clock does.
- R9: A second device whose `sdin` is fed from `ser_fast`, or from `ser_slow`, of the first device on the same clock receives the first device's last-stage bits. The two devices together act as one chain of twice the length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Shift clock; the chain moves on the rising edge, the slow tap on the falling edge |
| rst_n | input | 1 | Active-low asynchronous clear of all storage |
| sdin | input | 1 | Serial data into stage 1 |
| strobe | input | 1 | High: latches transparent; falling edge: latches hold |
| oe | input | 1 | Parallel output enable, active high |
| par_bus | output | STAGES | Three-state parallel bus, released while `oe` is low |
| par_data | output | STAGES | Latched parallel word, always driven |
| par_drive | output | 1 | Drive flag that goes with `par_data` |
| ser_fast | output | 1 | Cascade output, updated on the rising edge |
| ser_slow | output | 1 | Cascade output, updated on the following falling edge |

## Verification
The bench looks for the half-cycle gap between the two cascade outputs by sampling `ser_slow` both just after the rising edge and just after the falling edge. A tap on the wrong edge, or a tap that took the second-to-last stage, shows up there as a bit that arrives early or arrives one place off. It runs the clock for a full word with `strobe` low; a latch that is edge-triggered on the clock, or that is transparent on the wrong level, would let the word move. It shifts with `oe` low and then raises `oe` to show that the enable only gates the drive flag and the bus and never stops the chain. Two cascaded devices, one fed from each serial output, must hold the first device's older bits; a bit-order or stage-count error would scramble them.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
    // Number of shift/store stages when the parent does not override it.
    localparam int SSR_STAGES_DEFAULT = 8;
endpackage

// File: rtl/ssr_shift_chain.sv
`timescale 1ns/1ps
module ssr_shift_chain #(
    parameter int STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    output logic [STAGES-1:0] stages
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] feed;

    // Stage 0 takes the serial input; every later stage takes its neighbour.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_feed
            if (g == 0) begin : g_head
                assign feed[g] = din;
            end else begin : g_body
                assign feed[g] = stages[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stages <= '0;
        end else begin
            stages <= feed;
        end
    end

    AST_HEAD_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stages[0] == $past(din))); // R1
    AST_BODY_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stages[LAST:1] == $past(stages[LAST-1:0]))); // R1
endmodule

// File: rtl/ssr_slow_tap.sv
`timescale 1ns/1ps
module ssr_slow_tap (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic slow
);
    // Falling-edge retime of the last stage for low-speed cascades.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow <= 1'b0;
        end else begin
            slow <= fast;
        end
    end

    AST_SLOW_LAGS_FAST: assert property (@(negedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (slow == $past(fast))); // R3
endmodule

// File: rtl/ssr_store_bank.sv
`timescale 1ns/1ps
module ssr_store_bank #(
    parameter int STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [STAGES-1:0] d,
    output logic [STAGES-1:0] q
);
    // Level-sensitive store: open while strobe is high, closed on its fall.
    always_latch begin
        if (!rst_n) begin
            q <= '0;
        end else if (strobe) begin
            q <= d;
        end
    end
endmodule

// File: rtl/shift_store_reg.sv
`timescale 1ns/1ps
module shift_store_reg #(
    parameter int STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              sdin,
    input  logic              strobe,
    input  logic              oe,
    output logic [STAGES-1:0] par_bus,
    output logic [STAGES-1:0] par_data,
    output logic              par_drive,
    output logic              ser_fast,
    output logic              ser_slow
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stage_vec;
    logic [STAGES-1:0] held;

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk    (sclk),
        .rst_n  (rst_n),
        .din    (sdin),
        .stages (stage_vec)
    );

    assign ser_fast = stage_vec[LAST];

    ssr_slow_tap u_tap (
        .clk   (sclk),
        .rst_n (rst_n),
        .fast  (ser_fast),
        .slow  (ser_slow)
    );

    ssr_store_bank #(.STAGES(STAGES)) u_store (
        .rst_n  (rst_n),
        .strobe (strobe),
        .d      (stage_vec),
        .q      (held)
    );

    // Two views of the parallel word: vector plus flag, and a three-state bus.
    assign par_data  = held;
    assign par_drive = oe;
    assign par_bus   = oe ? held : {STAGES{1'bz}};

    AST_FAST_IS_LAST: assert property (@(posedge sclk) disable iff (!rst_n)
        $past(rst_n) |-> (ser_fast == $past(stage_vec[LAST-1]))); // R2
    AST_OPEN_FOLLOWS: assert property (@(negedge sclk) disable iff (!rst_n)
        strobe |-> (par_data == stage_vec)); // R4
    AST_CLOSED_HOLDS: assert property (@(posedge sclk) disable iff (!rst_n)
        ($past(rst_n) && !strobe && !$past(strobe)) |-> $stable(par_data)); // R5
endmodule

// File: tb/shift_store_reg_test.sv
`timescale 1ns/1ps
module shift_store_reg_test;
    logic sclk = 1'b0;
    logic rst_n, sdin, strobe, oe;
    wire [7:0] a_bus, b_bus, c_bus;
    wire [7:0] a_data, b_data, c_data;
    wire a_drv, b_drv, c_drv;
    wire a_fast, a_slow, b_fast, b_slow, c_fast, c_slow;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] ref_a, ref_b, lat_a, lat_b;
    logic ref_slow;

    always #4 sclk = ~sclk;

    shift_store_reg uut (
        .sclk(sclk), .rst_n(rst_n), .sdin(sdin), .strobe(strobe), .oe(oe),
        .par_bus(a_bus), .par_data(a_data), .par_drive(a_drv),
        .ser_fast(a_fast), .ser_slow(a_slow));
    shift_store_reg dev_b (
        .sclk(sclk), .rst_n(rst_n), .sdin(a_fast), .strobe(strobe), .oe(oe),
        .par_bus(b_bus), .par_data(b_data), .par_drive(b_drv),
        .ser_fast(b_fast), .ser_slow(b_slow));
    shift_store_reg dev_c (
        .sclk(sclk), .rst_n(rst_n), .sdin(a_slow), .strobe(strobe), .oe(oe),
        .par_bus(c_bus), .par_data(c_data), .par_drive(c_drv),
        .ser_fast(c_fast), .ser_slow(c_slow));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    task automatic chk_par();
        chk("R4 R5 parallel word", {8'h0, a_data}, {8'h0, lat_a});
        if (oe) begin
            chk("R6 drive flag on", {15'h0, a_drv}, 16'h1);
            chk("R6 bus equals word", {8'h0, a_bus}, {8'h0, lat_a});
        end else begin
            chk("R6 drive flag off", {15'h0, a_drv}, 16'h0);
        end
    endtask

    // One clock: drive sdin now (after a falling edge), check after both edges.
    task automatic step(input logic d);
        logic old_last;
        sdin = d;
        @(posedge sclk); #1;
        old_last = ref_a[7];
        ref_b = {ref_b[6:0], old_last};
        ref_a = {ref_a[6:0], d};
        if (strobe) begin
            lat_a = ref_a;
            lat_b = ref_b;
        end
        chk("R1 R2 R7 fast output", {15'h0, a_fast}, {15'h0, ref_a[7]});
        chk("R3 slow holds after rise", {15'h0, a_slow}, {15'h0, ref_slow});
        chk_par();
        chk("R9 cascade via fast", {8'h0, b_data}, {8'h0, lat_b});
        chk("R9 cascade via slow", {8'h0, c_data}, {8'h0, lat_b});
        @(negedge sclk); #1;
        ref_slow = ref_a[7];
        chk("R3 R7 slow after fall", {15'h0, a_slow}, {15'h0, ref_slow});
    endtask

    task automatic set_strobe(input logic v);
        strobe = v;
        #1;
        if (v) begin
            lat_a = ref_a;
            lat_b = ref_b;
        end
        chk("R4 R5 strobe change", {8'h0, a_data}, {8'h0, lat_a});
    endtask

    task automatic shift_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) step(b[i]);
    endtask

    task automatic t_reset_state();
        chk("R8 word cleared", {8'h0, a_data}, 16'h0);
        chk("R8 fast cleared", {15'h0, a_fast}, 16'h0);
        chk("R8 slow cleared", {15'h0, a_slow}, 16'h0);
        chk("R6 flag off in reset", {15'h0, a_drv}, 16'h0);
    endtask

    task automatic t_transparent();
        oe = 1'b1;
        set_strobe(1'b1);
        shift_byte(8'hA5);
        chk("R4 word after A5", {8'h0, a_data}, 16'h00A5);
        chk("R1 bit order stage1 at bit0", {15'h0, a_data[0]}, 16'h1);
    endtask

    task automatic t_hold();
        set_strobe(1'b0);
        shift_byte(8'h3C);
        chk("R5 frozen across clocks", {8'h0, a_data}, 16'h00A5);
        set_strobe(1'b1);
        chk("R4 reopen shows chain", {8'h0, a_data}, 16'h003C);
    endtask

    task automatic t_oe_off();
        oe = 1'b0;
        #1;
        chk_par();
        shift_byte(8'hC9);
        oe = 1'b1;
        #1;
        chk("R6 R7 bus after enable", {8'h0, a_bus}, 16'h00C9);
        chk("R6 word unaffected", {8'h0, a_data}, 16'h00C9);
    endtask

    task automatic t_cascade();
        shift_byte(8'h81);
        shift_byte(8'h6E);
        chk("R9 first byte in far device", {8'h0, b_data}, 16'h0081);
        chk("R9 first byte via slow tap", {8'h0, c_data}, 16'h0081);
        chk("R9 second byte in near device", {8'h0, a_data}, 16'h006E);
    endtask

    task automatic t_mid_reset();
        rst_n = 1'b0;
        #1;
        ref_a = '0; ref_b = '0; lat_a = '0; lat_b = '0; ref_slow = 1'b0;
        chk("R8 async clear word", {8'h0, a_data}, 16'h0);
        chk("R8 async clear far word", {8'h0, b_data}, 16'h0);
        @(posedge sclk); #1;
        chk("R8 no shift in reset", {15'h0, a_fast}, 16'h0);
        @(negedge sclk); #1;
        chk("R8 slow cleared", {15'h0, a_slow}, 16'h0);
        rst_n = 1'b1;
        shift_byte(8'h01);
        chk("R1 R8 restart", {8'h0, a_data}, 16'h0001);
    endtask

    initial begin
        rst_n = 1'b0; sdin = 1'b0; strobe = 1'b0; oe = 1'b0;
        ref_a = '0; ref_b = '0; lat_a = '0; lat_b = '0; ref_slow = 1'b0;
        repeat (2) @(negedge sclk);
        #1;
        t_reset_state();
        rst_n = 1'b1;
        t_transparent();
        t_hold();
        t_oe_off();
        t_cascade();
        t_mid_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at %0t: actual running expected finished", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule